// File: doc/BRIEF.md
# Watermark Boost Frequency Controller

This block converts activity-monitor events into a memory clock request. A monitor channel measures bus activity over a sampling period. It raises a "consecutive above" event when activity stays high across periods, and a "consecutive below" event when activity stays low. Each event comes with the latest averaged count. The controller keeps one boost term for the channel. An above event grows the boost multiplicatively and adds a fixed step. A below event shrinks the boost multiplicatively. Each event also turns on the event enable for the opposite direction. The enable for the same direction is turned off when the boost reaches its ceiling or falls to its floor.

Four watermarks are recomputed combinationally and fed back to the monitor. Two raw watermarks are derived from the current clock frequency, the period and two threshold percentages. Two average watermarks form a band around the stored average; the band width scales with the maximum frequency. The target frequency in kHz is the stored average divided by the period, scaled up by the inverse of the upper threshold, plus the boost.

A `start` pulse re-arms the channel. It clears the boost and seeds the average from the current frequency times the period. Choosing an operating point from the target is left to the consumer.

Top module: `wm_boost_ctrl`

## Requirements
- R1: After reset the boost is 0, both enables (`en_above`, `en_below`) are 0 and the stored average is 0.
- R2: A `start` pulse sets the boost to 0 and the stored average to min(cur_khz×period_ms, 2^32−1). It sets `en_above` to 1 and `en_below` to 0. `start` takes priority over an event in the same cycle.
- R3: On an event with `evt_up`=1, the new boost is min(boost×up_coef/100, 2^32−1) + 16000, using truncating division. If that value is ≥ max_khz, the boost becomes max_khz and `en_above` is cleared; otherwise `en_above` is unchanged. `en_below` is set in every case.
- R4: On an event with `evt_up`=0 and `evt_dn`=1, the new boost is min(boost×dn_coef/100, 2^32−1). If the result is below 8000, the boost becomes 0 and `en_below` is cleared; otherwise `en_below` is unchanged. `en_above` is set in every case.
- R5: When `evt_up` and `evt_dn` are both 1 in one event, only the R3 update is applied.
- R6: An event with both flags 0, or a cycle with neither `start` nor `evt_vld`, leaves the boost and both enables unchanged.
- R7: `wm_up` = min(cur_khz×period_ms×up_thr/100, 2^32−1) and `wm_dn` = min(cur_khz×period_ms×dn_thr/100, 2^32−1), using truncating division.
- R8: The band is min((max_khz×6/1000)×period_ms, 2^32−1), using truncating division. `avg_wm_up` = min(avg+band, 2^32−1). `avg_wm_dn` = avg−band when avg > band, and 0 otherwise.
- R9: `target_khz` = min((avg/P)×(10000/T)/100 + boost, 2^32−1), using truncating divisions. P is period_ms and T is up_thr, each taken as 1 when it is 0.
- R10: Every event (`evt_vld`=1 without `start`) loads the stored average from `avg_in`. The new value is visible on the outputs after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Re-arm pulse: clears the boost and seeds the average |
| evt_vld | input | 1 | Event strobe from the monitor |
| evt_up | input | 1 | Consecutive-above flag for this event |
| evt_dn | input | 1 | Consecutive-below flag for this event |
| avg_in | input | 32 | Averaged activity count that comes with the event |
| cur_khz | input | 32 | Current memory clock in kHz |
| max_khz | input | 32 | Maximum memory clock in kHz |
| period_ms | input | 9 | Sampling period in ms |
| up_coef | input | 10 | Boost growth percentage |
| dn_coef | input | 10 | Boost decay percentage |
| up_thr | input | 7 | Upper threshold percentage |
| dn_thr | input | 7 | Lower threshold percentage |
| target_khz | output | 32 | Requested frequency in kHz |
| boost_khz | output | 32 | Current boost term in kHz |
| wm_up | output | 32 | Raw upper watermark |
| wm_dn | output | 32 | Raw lower watermark |
| avg_wm_up | output | 32 | Average upper watermark |
| avg_wm_dn | output | 32 | Average lower watermark |
| en_above | output | 1 | Consecutive-above event enable |
| en_below | output | 1 | Consecutive-below event enable |

## Verification
The bench drives the boost up until it clamps at the maximum. A design that skipped the clamp would ask for more than the clock can deliver and would keep `en_above` armed. It then decays the boost down through the half-step threshold. A missing snap to zero would leave a small residual boost and keep `en_below` set. Events with both flags, with no flags, and with `start` in the same cycle catch a wrong priority order. Directed extremes catch a missing saturation or a floor that wraps: a 32-bit overflow of cur×period×threshold, an average close to 2^32−1, an average smaller than the band, and a zero period. Seeded random runs then compare every output with bench functions.

// File: rtl/wm_boost_ctrl.sv
module wm_boost_ctrl #(
  parameter int FW       = 32,
  parameter int PW       = 9,
  parameter int CW       = 10,
  parameter int TW       = 7,
  parameter int STEP_KHZ = 16000,
  parameter int BAND_PPT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          evt_vld,
  input  logic          evt_up,
  input  logic          evt_dn,
  input  logic [FW-1:0] avg_in,
  input  logic [FW-1:0] cur_khz,
  input  logic [FW-1:0] max_khz,
  input  logic [PW-1:0] period_ms,
  input  logic [CW-1:0] up_coef,
  input  logic [CW-1:0] dn_coef,
  input  logic [TW-1:0] up_thr,
  input  logic [TW-1:0] dn_thr,
  output logic [FW-1:0] target_khz,
  output logic [FW-1:0] boost_khz,
  output logic [FW-1:0] wm_up,
  output logic [FW-1:0] wm_dn,
  output logic [FW-1:0] avg_wm_up,
  output logic [FW-1:0] avg_wm_dn,
  output logic          en_above,
  output logic          en_below
);
  localparam logic [63:0] FMAX64 = (64'd1 << FW) - 64'd1;
  localparam logic [63:0] STEP64 = 64'(STEP_KHZ);
  localparam logic [63:0] HALF64 = 64'(STEP_KHZ / 2);

  function automatic logic [FW-1:0] sat(input logic [63:0] v);
    return (v > FMAX64) ? FMAX64[FW-1:0] : v[FW-1:0];
  endfunction

  logic [FW-1:0] boost_q, avg_q;
  logic          ab_q, bl_q;

  // boost arithmetic
  logic [63:0] grow_pct, grow_raw, decay_raw;
  logic        grow_clamp, decay_snap;
  assign grow_pct   = (64'(boost_q) * 64'(up_coef)) / 64'd100;
  assign grow_raw   = 64'(sat(grow_pct)) + STEP64;
  assign grow_clamp = grow_raw >= 64'(max_khz);
  assign decay_raw  = (64'(boost_q) * 64'(dn_coef)) / 64'd100;
  assign decay_snap = decay_raw < HALF64;

  logic [63:0] cur_per;
  assign cur_per = 64'(cur_khz) * 64'(period_ms);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boost_q <= '0;
      avg_q   <= '0;
      ab_q    <= 1'b0;
      bl_q    <= 1'b0;
    end else if (start) begin
      boost_q <= '0;
      avg_q   <= sat(cur_per);
      ab_q    <= 1'b1;
      bl_q    <= 1'b0;
    end else if (evt_vld) begin
      avg_q <= avg_in;
      if (evt_up) begin
        bl_q <= 1'b1;
        if (grow_clamp) begin
          boost_q <= max_khz;
          ab_q    <= 1'b0;
        end else begin
          boost_q <= grow_raw[FW-1:0];
        end
      end else if (evt_dn) begin
        ab_q <= 1'b1;
        if (decay_snap) begin
          boost_q <= '0;
          bl_q    <= 1'b0;
        end else begin
          boost_q <= sat(decay_raw);
        end
      end
    end
  end

  // raw watermarks
  assign wm_up = sat((cur_per * 64'(up_thr)) / 64'd100);
  assign wm_dn = sat((cur_per * 64'(dn_thr)) / 64'd100);

  // average band
  logic [63:0] band64;
  logic [FW-1:0] band;
  assign band64    = ((64'(max_khz) * 64'(BAND_PPT)) / 64'd1000) * 64'(period_ms);
  assign band      = sat(band64);
  assign avg_wm_up = sat(64'(avg_q) + 64'(band));
  assign avg_wm_dn = (avg_q > band) ? (avg_q - band) : '0;

  // target
  logic [63:0] per_div, thr_div, sustain, scaled;
  assign per_div    = (period_ms == '0) ? 64'd1 : 64'(period_ms);
  assign thr_div    = (up_thr == '0) ? 64'd1 : 64'(up_thr);
  assign sustain    = 64'd10000 / thr_div;
  assign scaled     = ((64'(avg_q) / per_div) * sustain) / 64'd100;
  assign target_khz = sat(scaled + 64'(boost_q));

  assign boost_khz = boost_q;
  assign en_above  = ab_q;
  assign en_below  = bl_q;
endmodule

module wm_boost_ctrl_chk #(
  parameter int FW       = 32,
  parameter int STEP_KHZ = 16000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          evt_vld,
  input logic          evt_up,
  input logic          evt_dn,
  input logic [FW-1:0] max_khz,
  input logic [FW-1:0] boost_khz,
  input logic [FW-1:0] target_khz,
  input logic [FW-1:0] avg_wm_up,
  input logic [FW-1:0] avg_wm_dn,
  input logic          en_above,
  input logic          en_below
);
  AST_START_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (boost_khz == '0) && en_above && !en_below); // R2
  AST_UP_ARMS_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vld && evt_up && !start) |=> en_below); // R3
  AST_UP_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vld && evt_up && !start) |=> (boost_khz <= $past(max_khz))); // R3
  AST_DN_ARMS_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vld && !evt_up && evt_dn && !start) |=> en_above); // R4
  AST_DN_NO_RESIDUE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vld && !evt_up && evt_dn && !start) |=>
      ((boost_khz == '0) || (32'(boost_khz) >= 32'(STEP_KHZ / 2)))); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && (!evt_vld || (!evt_up && !evt_dn))) |=>
      ($stable(boost_khz) && $stable(en_above) && $stable(en_below))); // R6
  AST_BAND_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    avg_wm_dn <= avg_wm_up); // R8
  AST_TARGET_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    target_khz >= boost_khz); // R9
endmodule

bind wm_boost_ctrl wm_boost_ctrl_chk #(.FW(FW), .STEP_KHZ(STEP_KHZ)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .evt_vld(evt_vld), .evt_up(evt_up),
  .evt_dn(evt_dn), .max_khz(max_khz), .boost_khz(boost_khz),
  .target_khz(target_khz), .avg_wm_up(avg_wm_up), .avg_wm_dn(avg_wm_dn),
  .en_above(en_above), .en_below(en_below));

// File: tb/tb_wm_boost_ctrl.sv
module tb_wm_boost_ctrl;
  typedef longint unsigned u64;
  localparam u64 M32 = 64'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, evt_vld = 1'b0, evt_up = 1'b0, evt_dn = 1'b0;
  logic [31:0] avg_in = '0, cur_khz = '0, max_khz = '0;
  logic [8:0]  period_ms = '0;
  logic [9:0]  up_coef = '0, dn_coef = '0;
  logic [6:0]  up_thr = '0, dn_thr = '0;
  logic [31:0] target_khz, boost_khz, wm_up, wm_dn, avg_wm_up, avg_wm_dn;
  logic        en_above, en_below;

  always #4 clk = ~clk;

  wm_boost_ctrl dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  u64 m_boost, m_avg;
  bit m_ab, m_bl;

  function automatic u64 sat(u64 v);
    return (v > M32) ? M32 : v;
  endfunction
  function automatic u64 e_wm(u64 c, u64 p, u64 t);
    return sat(c * p * t / 100);
  endfunction
  function automatic u64 e_band(u64 mx, u64 p);
    return sat((mx * 6 / 1000) * p);
  endfunction
  function automatic u64 e_target(u64 a, u64 p, u64 t, u64 b);
    u64 pp = (p == 0) ? 1 : p;
    u64 tt = (t == 0) ? 1 : t;
    return sat((a / pp) * (10000 / tt) / 100 + b);
  endfunction

  task automatic chk(string tag, u64 act, u64 exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    u64 b = e_band(max_khz, period_ms);
    chk({tag, " boost"}, boost_khz, m_boost);
    chk({tag, " en_above"}, en_above, m_ab);
    chk({tag, " en_below"}, en_below, m_bl);
    chk("R9 target", target_khz, e_target(m_avg, period_ms, up_thr, m_boost));
    chk("R7 wm_up", wm_up, e_wm(cur_khz, period_ms, up_thr));
    chk("R7 wm_dn", wm_dn, e_wm(cur_khz, period_ms, dn_thr));
    chk("R8 avg_wm_up", avg_wm_up, sat(m_avg + b));
    chk("R8 avg_wm_dn", avg_wm_dn, (m_avg > b) ? m_avg - b : 0);
  endtask

  task automatic model_evt(bit up, bit dn, u64 a);
    u64 v;
    m_avg = a;
    if (up) begin
      v = sat(m_boost * up_coef / 100) + 16000;
      m_bl = 1;
      if (v >= max_khz) begin v = max_khz; m_ab = 0; end
      m_boost = v;
    end else if (dn) begin
      v = sat(m_boost * dn_coef / 100);
      m_ab = 1;
      if (v < 8000) begin v = 0; m_bl = 0; end
      m_boost = v;
    end
  endtask

  task automatic do_evt(bit up, bit dn, logic [31:0] a, string tag);
    @(negedge clk);
    evt_vld = 1; evt_up = up; evt_dn = dn; avg_in = a;
    @(negedge clk);
    evt_vld = 0; evt_up = 0; evt_dn = 0;
    model_evt(up, dn, a);
    chk_all(tag);
  endtask

  task automatic do_start(bit with_evt, string tag);
    @(negedge clk);
    start = 1;
    if (with_evt) begin evt_vld = 1; evt_up = 1; avg_in = 32'h1234; end
    @(negedge clk);
    start = 0; evt_vld = 0; evt_up = 0;
    m_boost = 0; m_ab = 1; m_bl = 0;
    m_avg = sat(u64'(cur_khz) * period_ms);
    chk_all(tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    cur_khz = 400000; max_khz = 800000; period_ms = 12;
    up_coef = 200; dn_coef = 50; up_thr = 60; dn_thr = 40;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    m_boost = 0; m_avg = 0; m_ab = 0; m_bl = 0;
    chk_all("R1 reset");

    do_start(0, "R2 start");
    // growth to clamp: 16000,48000,112000,240000,496000,800000(clamp)
    for (int i = 0; i < 7; i++) do_evt(1, 0, 32'd3000000 + i, "R3 grow");
    chk("R3 clamp value", boost_khz, 800000);
    chk("R3 clamp clears en_above", en_above, 0);
    do_evt(0, 0, 32'd5000, "R10 avg load");
    chk("R10 target uses new avg", target_khz, e_target(5000, 12, 60, 800000));
    // decay to snap: 400000..12500, 6250 -> 0
    for (int i = 0; i < 8; i++) do_evt(0, 1, 32'd4000000, "R4 decay");
    chk("R4 snap to zero", boost_khz, 0);
    chk("R4 snap clears en_below", en_below, 0);
    do_evt(1, 1, 32'd100, "R5 both flags");
    chk("R5 upper wins", boost_khz, 16000);
    do_evt(0, 0, 32'd777, "R6 no flags");
    repeat (4) @(negedge clk);
    chk_all("R6 idle");
    do_start(1, "R2 start priority");

    // extremes
    cur_khz = 32'hFFFF_FFFF; period_ms = 256; up_thr = 100; dn_thr = 99;
    @(negedge clk); chk_all("R7 saturate");
    max_khz = 32'hFFFF_FFFF;
    do_evt(0, 0, 32'hFFFF_FFF0, "R8 high avg");
    do_evt(0, 0, 32'd10, "R8 floor");
    period_ms = 0; up_thr = 0;
    do_evt(1, 0, 32'd90000, "R9 zero divisors");

    // seeded random
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      max_khz   = 200000 + ($urandom % 2000000);
      cur_khz   = $urandom % (max_khz + 1);
      period_ms = 9'(1 + ($urandom % 256));
      up_coef   = 10'(($urandom % 3 == 0) ? 200 : ($urandom % 2 == 0) ? 800 : 100 + $urandom % 900);
      dn_coef   = 10'(($urandom % 2 == 0) ? 40 : $urandom % 100);
      up_thr    = 7'(1 + $urandom % 100);
      dn_thr    = 7'($urandom % 100);
      if ($urandom % 25 == 0) do_start(0, "R2 rand start");
      else do_evt(1'($urandom), 1'($urandom), $urandom, "R3/R4 rand");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule